// File: doc/BRIEF.md
# Lockable Horizontal Sync Generator

This block produces the horizontal timing of a display output path from a single pixel clock. It keeps a pixel position within the current line. From that position it drives a horizontal sync pulse of fixed length at the start of every line, a blanking flag that is low only inside the active-video window, and a one-cycle strobe at each line start.

Line timing comes from one of two sources. In free-running mode the line length is a programmed count of clock cycles. In locked mode every rising edge of an incoming horizontal sync restarts the line. If the incoming edges stop, the programmed length still wraps the line, so the output sync keeps running. The active window can be trimmed by the same number of pixels at both ends, which hides the edge artifacts of downstream filters. The configuration inputs are treated as static. The block copies them into shadow registers only at a line start, so a change made in the middle of a line never produces a runt pulse.

A single flag reports the one mode pairing that is not supported: horizontal timing locked while vertical timing runs free.

The line controller is a three-state machine:
- `ST_IDLE` is held during reset and lasts one cycle after it.
- `ST_SYNC` covers the sync-pulse part of the line.
- `ST_BODY` covers the rest of the line.

Its transitions are:
- *start*: `ST_IDLE` to `ST_SYNC`.
- *pulse end*: `ST_SYNC` to `ST_BODY`, taken after the last pulse cycle.
- *restart*: `ST_SYNC` or `ST_BODY` back to `ST_SYNC`, taken on a length wrap or, in locked mode, on an input sync edge.

Top module: `hsync_gen`

## Requirements
- R1: While `rst_n` is low, and for one cycle after it rises, `hsync_out` is 0, `blank_out` is 1 and `line_start` is 0. The first line then starts with position 0.
- R2: The sync pulse is active for exactly 64 cycles, at line positions 0 to 63, unless a restart cuts the line short. `line_start` is 1 only at position 0 of each line.
- R3: `hsync_out` equals the active-high pulse XOR the polarity setting `cfg_pol`. With `cfg_pol` = 0 the pulse is high; with `cfg_pol` = 1 it is low.
- R4: In free-running mode (`cfg_h_free` = 1) the line period is exactly `cfg_line_len` cycles. Positions run from 0 to `cfg_line_len`-1.
- R5: In locked mode (`cfg_h_free` = 0) a rising edge of `hsync_in` restarts the line. `line_start` is 1 in the cycle after the third rising clock edge that samples `hsync_in` high. Holding `hsync_in` high causes only one restart.
- R6: In free-running mode `hsync_in` has no effect on any output.
- R7: In locked mode with no input edge, the line still wraps after `cfg_line_len` cycles.
- R8: `blank_out` is 0 exactly at positions p with `cfg_act_start`+`cfg_trim` <= p < `cfg_act_start`+`cfg_act_width`-`cfg_trim`, and 1 everywhere else.
- R9: When 2*`cfg_trim` >= `cfg_act_width`, `blank_out` stays 1 for the whole line.
- R10: The mode, polarity, line length, window start, width and trim values take effect only at the next line start.
- R11: `cfg_bad` is 1 exactly when `cfg_h_free` = 0 and `cfg_v_free` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_in | input | 1 | Incoming horizontal sync, asynchronous, rising edge active |
| cfg_h_free | input | 1 | 1: horizontal free-running, 0: locked to `hsync_in` |
| cfg_v_free | input | 1 | Vertical mode, used only for the combination flag |
| cfg_pol | input | 1 | Output sync polarity, 1 inverts |
| cfg_line_len | input | LINE_W | Line length in clock cycles |
| cfg_act_start | input | LINE_W | First column of the nominal active region |
| cfg_act_width | input | LINE_W | Width of the nominal active region |
| cfg_trim | input | LINE_W | Pixels removed from each end of the active region |
| hsync_out | output | 1 | Horizontal sync pulse |
| blank_out | output | 1 | 1 outside the active window |
| line_start | output | 1 | One-cycle strobe at position 0 of each line |
| cfg_bad | output | 1 | Unsupported mode combination requested |

## Verification
The outputs are combinational decodes of the registered position and state. `hsync_out`, `blank_out` and `line_start` therefore show the result of a clock edge in the same cycle. An input sync edge reaches `line_start` three edges after it is first sampled. A configuration change shows up only from the next line start. `cfg_bad` follows its inputs without delay. The bench advances a behavioural model at every rising edge, with a three-deep sample queue for the input sync latency. It compares all four outputs a quarter period later, while the inputs are still stable.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_BODY = 2'd2
    } hsg_state_e;

endpackage

// File: rtl/hsg_edge_sync.sv
module hsg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], sig_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R5

endmodule

// File: rtl/hsg_line_fsm.sv
module hsg_line_fsm
    import hsg_pkg::*;
#(
    parameter int LINE_W   = 12,
    parameter int SYNC_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              cfg_locked,
    input  logic              cfg_pol,
    input  logic [LINE_W-1:0] cfg_len,
    input  logic [LINE_W-1:0] cfg_start,
    input  logic [LINE_W-1:0] cfg_width,
    input  logic [LINE_W-1:0] cfg_trim,
    output logic [LINE_W-1:0] pos,
    output logic              run,
    output logic              line_start,
    output logic              hs_out,
    output logic [LINE_W-1:0] sh_start,
    output logic [LINE_W-1:0] sh_width,
    output logic [LINE_W-1:0] sh_trim
);

    localparam logic [LINE_W-1:0] PULSE_LAST = LINE_W'(SYNC_LEN - 1);
    localparam logic [LINE_W-1:0] PULSE_LEN  = LINE_W'(SYNC_LEN);

    hsg_state_e        st, st_nx;
    logic [LINE_W-1:0] cnt, cnt_nx;
    logic              load;
    logic              wrap;
    logic              hs_act;

    logic              sh_locked;
    logic              sh_pol;
    logic [LINE_W-1:0] sh_len;
    logic [LINE_W-1:0] len_last;

    assign len_last = sh_len - 1'b1;
    assign wrap     = (cnt == len_last) || (sh_locked && rise);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // shadow configuration, captured only at a line start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_locked <= 1'b0;
            sh_pol    <= 1'b0;
            sh_len    <= '0;
            sh_start  <= '0;
            sh_width  <= '0;
            sh_trim   <= '0;
        end else if (load) begin
            sh_locked <= cfg_locked;
            sh_pol    <= cfg_pol;
            sh_len    <= cfg_len;
            sh_start  <= cfg_start;
            sh_width  <= cfg_width;
            sh_trim   <= cfg_trim;
        end
    end

    // next state
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        load   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                st_nx  = ST_SYNC;
                cnt_nx = '0;
                load   = 1'b1;
            end
            ST_SYNC, ST_BODY: begin
                if (wrap) begin
                    st_nx  = ST_SYNC;
                    cnt_nx = '0;
                    load   = 1'b1;
                end else begin
                    cnt_nx = cnt + 1'b1;
                    if (st == ST_SYNC && cnt == PULSE_LAST) begin
                        st_nx = ST_BODY;
                    end
                end
            end
            default: begin
                st_nx  = ST_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        run        = (st != ST_IDLE);
        hs_act     = (st == ST_SYNC);
        line_start = (st == ST_SYNC) && (cnt == '0);
        hs_out     = hs_act ^ sh_pol;
        pos        = cnt;
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (hs_out != sh_pol)); // R2
    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SYNC) |-> (cnt < PULSE_LEN)); // R2
    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sh_len != '0) |-> (cnt <= len_last)); // R4
    AST_LOCK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sh_locked && rise) |=> line_start); // R5
    AST_FREE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sh_locked && rise && cnt != len_last) |=> (cnt == $past(cnt) + 1'b1)); // R6

endmodule

// File: rtl/hsg_window.sv
module hsg_window #(
    parameter int LINE_W = 12
) (
    input  logic              run,
    input  logic [LINE_W-1:0] pos,
    input  logic [LINE_W-1:0] start,
    input  logic [LINE_W-1:0] width,
    input  logic [LINE_W-1:0] trim,
    output logic              active
);

    localparam int EW = LINE_W + 2;

    logic [EW-1:0] p_e, lo, hi, trim2, width_e;
    logic          fits;

    always_comb begin
        p_e     = EW'(pos);
        trim2   = EW'(trim) << 1;
        width_e = EW'(width);
        fits    = trim2 < width_e;
        lo      = EW'(start) + EW'(trim);
        hi      = EW'(start) + width_e - EW'(trim);
        active  = run && fits && (p_e >= lo) && (p_e < hi);
    end

endmodule

// File: rtl/hsync_gen.sv
module hsync_gen #(
    parameter int LINE_W      = 12,
    parameter int SYNC_LEN    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              cfg_h_free,
    input  logic              cfg_v_free,
    input  logic              cfg_pol,
    input  logic [LINE_W-1:0] cfg_line_len,
    input  logic [LINE_W-1:0] cfg_act_start,
    input  logic [LINE_W-1:0] cfg_act_width,
    input  logic [LINE_W-1:0] cfg_trim,
    output logic              hsync_out,
    output logic              blank_out,
    output logic              line_start,
    output logic              cfg_bad
);

    logic              rise;
    logic              run;
    logic              active;
    logic [LINE_W-1:0] pos;
    logic [LINE_W-1:0] sh_start, sh_width, sh_trim;

    hsg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (hsync_in),
        .rise   (rise)
    );

    hsg_line_fsm #(.LINE_W(LINE_W), .SYNC_LEN(SYNC_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .cfg_locked (~cfg_h_free),
        .cfg_pol    (cfg_pol),
        .cfg_len    (cfg_line_len),
        .cfg_start  (cfg_act_start),
        .cfg_width  (cfg_act_width),
        .cfg_trim   (cfg_trim),
        .pos        (pos),
        .run        (run),
        .line_start (line_start),
        .hs_out     (hsync_out),
        .sh_start   (sh_start),
        .sh_width   (sh_width),
        .sh_trim    (sh_trim)
    );

    hsg_window #(.LINE_W(LINE_W)) u_win (
        .run    (run),
        .pos    (pos),
        .start  (sh_start),
        .width  (sh_width),
        .trim   (sh_trim),
        .active (active)
    );

    assign blank_out = ~active;
    assign cfg_bad   = ~cfg_h_free & cfg_v_free;

    AST_TRIM_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((LINE_W + 2)'(sh_trim) << 1) >= (LINE_W + 2)'(sh_width) |-> blank_out); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (blank_out && !line_start)); // R1

endmodule

// File: tb/sim_hsync_gen.sv
module sim_hsync_gen;

    localparam int CLK_P  = 10;
    localparam int LINE_W = 12;
    localparam int MASK   = (1 << LINE_W) - 1;
    localparam int PULSE  = 64;

    logic clk = 1'b0;
    logic rst_n;
    logic hsync_in;
    logic cfg_h_free, cfg_v_free, cfg_pol;
    logic [LINE_W-1:0] cfg_line_len, cfg_act_start, cfg_act_width, cfg_trim;
    logic hsync_out, blank_out, line_start, cfg_bad;

    int    total = 0;
    int    bad   = 0;
    string phase = "R1 reset";
    bit    armed = 1'b0;

    // behavioural reference state
    bit m_idle;
    int m_pos;
    bit m_lock, m_pol;
    int m_len, m_start, m_width, m_trim;
    bit hist[$];

    always #(CLK_P/2) clk = ~clk;

    hsync_gen #(.LINE_W(LINE_W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .hsync_in      (hsync_in),
        .cfg_h_free    (cfg_h_free),
        .cfg_v_free    (cfg_v_free),
        .cfg_pol       (cfg_pol),
        .cfg_line_len  (cfg_line_len),
        .cfg_act_start (cfg_act_start),
        .cfg_act_width (cfg_act_width),
        .cfg_trim      (cfg_trim),
        .hsync_out     (hsync_out),
        .blank_out     (blank_out),
        .line_start    (line_start),
        .cfg_bad       (cfg_bad)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %b expected %b", phase, what, act, exp);
        end
    endtask

    task automatic take_cfg();
        m_lock  = !cfg_h_free;
        m_pol   = cfg_pol;
        m_len   = int'(cfg_line_len);
        m_start = int'(cfg_act_start);
        m_width = int'(cfg_act_width);
        m_trim  = int'(cfg_trim);
    endtask

    task automatic compare();
        bit pulse, act, ls;
        pulse = !m_idle && (m_pos < PULSE);
        ls    = !m_idle && (m_pos == 0);
        act   = !m_idle && (2 * m_trim < m_width) &&
                (m_pos >= m_start + m_trim) && (m_pos < m_start + m_width - m_trim);
        chk("R2 R3 hsync_out", hsync_out, pulse ^ m_pol);
        chk("R8 blank_out", blank_out, !act);
        chk("R4 line_start", line_start, ls);
        chk("R11 cfg_bad", cfg_bad, !cfg_h_free && cfg_v_free);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idle = 1'b1;
            m_pos  = 0;
            m_lock = 1'b0; m_pol = 1'b0;
            m_len = 0; m_start = 0; m_width = 0; m_trim = 0;
            hist   = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit edge_seen;
            // hist[0]: sampled one edge ago, hist[1]: two ago, hist[2]: three ago
            edge_seen = hist[1] && !hist[2];
            if (m_idle) begin
                m_idle = 1'b0;
                m_pos  = 0;
                take_cfg();
            end else if (m_pos == ((m_len - 1) & MASK) || (m_lock && edge_seen)) begin
                m_pos = 0;
                take_cfg();
            end else begin
                m_pos = (m_pos + 1) & MASK;
            end
            hist.push_front(hsync_in);
            void'(hist.pop_back());
        end
        armed = 1'b1;
        #(CLK_P/4);
        if (armed) compare();
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hsync_in = 1'b0;
        cfg_h_free = 1'b1; cfg_v_free = 1'b0; cfg_pol = 1'b0;
        cfg_line_len = 12'd200; cfg_act_start = 12'd80;
        cfg_act_width = 12'd100; cfg_trim = 12'd0;
        step(4);
        rst_n = 1'b1;
        phase = "R1 leaving reset";
        step(2);
        phase = "R2 R4 free-run";
        step(600);
        phase = "R6 input ignored when free";
        repeat (6) begin
            hsync_in = 1'b1; step(7);
            hsync_in = 1'b0; step(61);
        end
        phase = "R3 polarity";
        cfg_pol = 1'b1;
        step(450);
        phase = "R8 trimmed window";
        cfg_trim = 12'd10;
        step(450);
        phase = "R9 trim consumes width";
        cfg_trim = 12'd50;
        step(450);
        cfg_trim = 12'd60;
        step(300);
        phase = "R10 mid-line change";
        step(37);
        cfg_trim = 12'd5; cfg_line_len = 12'd150;
        cfg_act_start = 12'd20; cfg_act_width = 12'd90; cfg_pol = 1'b0;
        step(500);
        phase = "R5 locked";
        cfg_h_free = 1'b0; cfg_line_len = 12'd300;
        repeat (8) begin
            hsync_in = 1'b1; step(10);
            hsync_in = 1'b0; step(160);
        end
        hsync_in = 1'b1; step(30);
        hsync_in = 1'b0; step(40);
        hsync_in = 1'b1; step(400);
        hsync_in = 1'b0; step(50);
        phase = "R7 lock timeout";
        step(900);
        phase = "R11 mode combo";
        cfg_v_free = 1'b1; step(20);
        cfg_h_free = 1'b1; step(20);
        cfg_v_free = 1'b0; step(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule